// File: doc/BRIEF.md
# DS3 Error Event Tally Bank

This block gathers single-cycle error strobes from a DS3 receive framer and keeps one running tally per error class. There are six classes: framing-bit errors, line code violations, excessive-zero occurrences, P-parity errors, C-bit parity errors and far-end block errors. Counting has no qualifier. Strobes are counted whatever the framer's alignment state, including while it is out of frame.

Software polls the block about once a second through a small byte-wide register port. A write that sets the transfer bit copies all six tallies into holding registers on the same clock edge. The same edge restarts every tally. Software then reads the frozen values one byte at a time. A sticky completion flag marks that new values are ready, and it can drive an interrupt line when enabled.

Top module: `ds3_errtally`

## Requirements
- R1: `errStrobe` carries one bit per class: bit 0 framing-bit error, bit 1 line code violation, bit 2 excessive zeros, bit 3 P-parity, bit 4 C-bit parity, bit 5 far-end block error. Each class has its own independent tally.
- R2: A strobe bit high at a rising clock edge adds exactly one to its class tally. No other input or framing condition gates the count.
- R3: Each tally is CNT_W bits wide, 16 by default, which is above the roughly 44,736 events one second of DS3 gives at a 1e-3 error rate. A tally holds at 2^CNT_W-1 instead of wrapping.
- R4: Writing address 0x00 with data bit 0 set is a transfer. At that edge all six tallies are copied into their holding registers. Each tally restarts at 1 if its strobe is high in that same cycle, and at 0 otherwise.
- R5: Holding values are read at address 0x10 + 2*class for the low byte and 0x11 + 2*class for the high byte. `regRdata` is combinational while `regRd` is high.
- R6: Status bit 0 at address 0x01 is set at each transfer and cleared by a read of address 0x01.
- R7: Bit 1 of any write to address 0x00 sets the interrupt enable, which reads back at address 0x00 bit 1. `irqOut` is high exactly when the status bit and the enable are both set.
- R8: Reads of the holding registers change no tally and no holding value. A read of an unmapped address returns 0, and `regRdata` is 0 while `regRd` is low.
- R9: After reset, every tally, holding value, the status bit and the enable are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errStrobe | input | 6 | One strobe per error class |
| regWr | input | 1 | Register write enable |
| regRd | input | 1 | Register read enable |
| regAddr | input | ADDR_W (5) | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data |
| irqOut | output | 1 | Transfer-complete interrupt |

## Verification
The hardest state to reach from the ports is saturation. It needs more than 65,535 strobes in one interval, so the bench holds all six strobes high for slightly longer than that between two transfers and then reads the frozen 0xFFFF values. The boundary at the transfer edge is also checked. Strobes are held high during the transfer write, and the bench confirms they are credited to the new interval and not to the frozen one.

// File: rtl/errtally_pkg.sv
package errtally_pkg;
  localparam int N_EVT     = 6;
  localparam int EV_FRAME  = 0;
  localparam int EV_LCV    = 1;
  localparam int EV_EXZ    = 2;
  localparam int EV_PPAR   = 3;
  localparam int EV_CPAR   = 4;
  localparam int EV_FEBE   = 5;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int HOLD_BASE = 16;

  typedef struct packed {
    logic       xfer;
    logic       holdRd;
    logic [7:0] byteIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/errtally_cell.sv
module errtally_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         evt,
  input  logic         xfer,
  output logic [W-1:0] cnt,
  output logic [W-1:0] hold
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      hold <= '0;
    end else if (xfer) begin
      hold <= cnt;
      cnt  <= W'(evt);
    end else if (evt && cnt != MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!xfer && cnt == MAX) |=> cnt == MAX);
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!xfer && evt && cnt != MAX) |=> cnt == W'($past(cnt) + 1'b1));
  // R4
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    xfer |=> (hold == $past(cnt)) && (cnt == W'($past(evt))));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xfer |=> $stable(hold));
endmodule

// File: rtl/errtally_datapath.sv
module errtally_datapath
  import errtally_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_EVT-1:0] evt,
  input  ctrlStrobes_t     strb,
  output logic [7:0]       holdByte
);
  localparam int BPC   = (CNT_W + 7) / 8;
  localparam int SLOT  = BPC * 8;
  localparam int NBYTE = N_EVT * BPC;
  localparam int PAD   = SLOT - CNT_W;

  logic [NBYTE*8-1:0] holdFlat;

  for (genvar i = 0; i < N_EVT; i++) begin : g_cell
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold;

    errtally_cell #(.W(CNT_W)) u_cell (
      .clk (clk),
      .rstN(rstN),
      .evt (evt[i]),
      .xfer(strb.xfer),
      .cnt (cnt),
      .hold(hold)
    );

    if (PAD > 0) begin : g_pad
      assign holdFlat[i*SLOT +: SLOT] = {{PAD{1'b0}}, hold};
    end else begin : g_nopad
      assign holdFlat[i*SLOT +: SLOT] = hold;
    end
  end

  always_comb begin
    holdByte = '0;
    if (strb.holdRd && int'(strb.byteIdx) < NBYTE)
      holdByte = holdFlat[int'(strb.byteIdx)*8 +: 8];
  end
endmodule

// File: rtl/errtally_ctrl.sv
module errtally_ctrl
  import errtally_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic [7:0]        holdByte,
  output logic [7:0]        regRdata,
  output logic              irqOut,
  output ctrlStrobes_t      strb
);
  localparam int BPC   = (CNT_W + 7) / 8;
  localparam int NBYTE = N_EVT * BPC;

  logic irqEn;
  logic doneFlag;
  logic ctrlHit;
  logic statHit;
  logic holdHit;

  assign ctrlHit = (int'(regAddr) == CTRL_ADDR);
  assign statHit = (int'(regAddr) == STAT_ADDR);
  assign holdHit = (int'(regAddr) >= HOLD_BASE) && (int'(regAddr) < HOLD_BASE + NBYTE);

  always_comb begin
    strb.xfer    = regWr && ctrlHit && regWdata[0];
    strb.holdRd  = regRd && holdHit;
    strb.byteIdx = 8'(int'(regAddr) - HOLD_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (regWr && ctrlHit) irqEn <= regWdata[1];
      if (strb.xfer) doneFlag <= 1'b1;
      else if (regRd && statHit) doneFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      if (ctrlHit)      regRdata = {6'b0, irqEn, 1'b0};
      else if (statHit) regRdata = {7'b0, doneFlag};
      else if (holdHit) regRdata = holdByte;
    end
  end

  assign irqOut = doneFlag & irqEn;

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> doneFlag);
  // R6
  done_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && statHit && !strb.xfer) |=> !doneFlag);
  // R7
  en_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && ctrlHit) |=> $stable(irqEn));
  // R8
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |-> regRdata == 8'h00);
endmodule

// File: rtl/ds3_errtally.sv
module ds3_errtally
  import errtally_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        errStrobe,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irqOut
);
  ctrlStrobes_t strb;
  logic [7:0]   holdByte;

  errtally_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regRd   (regRd),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .holdByte(holdByte),
    .regRdata(regRdata),
    .irqOut  (irqOut),
    .strb    (strb)
  );

  errtally_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (errStrobe),
    .strb    (strb),
    .holdByte(holdByte)
  );
endmodule

// File: tb/ds3_errtally_tb.sv
module ds3_errtally_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] errStrobe = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       irqOut;

  always #4 clk = ~clk;

  ds3_errtally u_dut (
    .clk(clk), .rstN(rstN), .errStrobe(errStrobe), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string req = "R9";
  int    mCnt[6];
  int    mHold[6];
  bit    mDone = 0;
  bit    mEn = 0;

  function automatic logic [7:0] expData(input bit rd, input int a);
    int off;
    if (!rd) return 8'h00;
    if (a == 0) return {6'b0, mEn, 1'b0};
    if (a == 1) return {7'b0, mDone};
    if (a >= 16 && a < 28) begin
      off = a - 16;
      return (off % 2) ? 8'((mHold[off/2] >> 8) & 255) : 8'(mHold[off/2] & 255);
    end
    return 8'h00;
  endfunction

  task automatic cyc(input logic [5:0] ev, input bit wr, input bit rd,
                     input int a, input logic [7:0] wd);
    logic [7:0] e;
    @(negedge clk);
    errStrobe = ev; regWr = wr; regRd = rd; regAddr = 5'(a); regWdata = wd;
    #1;
    e = expData(rd, a);
    total++;
    if (regRdata !== e) begin
      bad++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", req, a, regRdata, e);
    end
    total++;
    if (irqOut !== (mDone & mEn)) begin
      bad++;
      $display("FAIL R7 irq actual=%b expected=%b", irqOut, mDone & mEn);
    end
    @(posedge clk);
    if (wr && a == 0 && wd[0]) begin
      for (int i = 0; i < 6; i++) begin
        mHold[i] = mCnt[i];
        mCnt[i]  = ev[i] ? 1 : 0;
      end
      mDone = 1;
    end else begin
      for (int i = 0; i < 6; i++)
        if (ev[i] && mCnt[i] < 65535) mCnt[i]++;
      if (rd && a == 1) mDone = 0;
    end
    if (wr && a == 0) mEn = wd[1];
  endtask

  task automatic xfer(input logic [5:0] ev);
    cyc(ev, 1, 0, 0, {6'b0, mEn, 1'b1});
  endtask

  task automatic readAll();
    for (int a = 16; a < 28; a++) cyc(6'h00, 0, 1, a, 8'h00);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int lfsr;
    for (int i = 0; i < 6; i++) begin mCnt[i] = 0; mHold[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R9 reset state: holdings, status, enable all zero
    req = "R9";
    readAll();
    cyc(6'h00, 0, 1, 1, 8'h00);
    cyc(6'h00, 0, 1, 0, 8'h00);

    // R1 each class alone gets distinct counts
    req = "R1";
    for (int i = 0; i < 6; i++)
      for (int k = 0; k <= i; k++) cyc(6'(1 << i), 0, 0, 0, 8'h00);
    xfer(6'h00);
    readAll();

    // R2 pseudo-random strobe patterns, interleaved transfers
    req = "R2";
    lfsr = 32'h1ACE5;
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h00B40000 : 0);
      if (k % 97 == 96) xfer(6'(lfsr));
      else cyc(6'(lfsr), 0, 0, 0, 8'h00);
    end
    xfer(6'h00);
    readAll();

    // R4 strobes in the transfer cycle start the new interval
    req = "R4";
    repeat (3) cyc(6'h2A, 0, 0, 0, 8'h00);
    xfer(6'h3F);
    readAll();
    xfer(6'h00);
    readAll();

    // R7 interrupt enable, readback, then R6 status clear on read
    req = "R7";
    cyc(6'h00, 1, 0, 0, 8'h02);
    cyc(6'h00, 0, 1, 0, 8'h00);
    xfer(6'h01);
    cyc(6'h00, 0, 0, 0, 8'h00);
    req = "R6";
    cyc(6'h00, 0, 1, 1, 8'h00);
    cyc(6'h00, 0, 1, 1, 8'h00);
    cyc(6'h00, 1, 0, 0, 8'h00);
    xfer(6'h00);
    cyc(6'h00, 0, 1, 1, 8'h00);

    // R8 repeated reads leave holdings and tallies untouched; unmapped reads 0
    req = "R8";
    repeat (5) cyc(6'h15, 0, 0, 0, 8'h00);
    xfer(6'h00);
    readAll();
    readAll();
    for (int a = 2; a < 16; a++) cyc(6'h00, 0, 1, a, 8'h00);
    for (int a = 28; a < 32; a++) cyc(6'h00, 0, 1, a, 8'h00);
    xfer(6'h00);
    readAll();

    // R3 saturation after more than 65535 strobes
    req = "R3";
    for (int k = 0; k < 65540; k++) cyc(6'h3F, 0, 0, 0, 8'h00);
    xfer(6'h00);
    readAll();
    xfer(6'h00);
    readAll();

    // R5 byte mapping with asymmetric high bytes
    req = "R5";
    for (int k = 0; k < 300; k++) cyc(6'(6'h01 | ((k % 2) ? 6'h20 : 6'h00)), 0, 0, 0, 8'h00);
    xfer(6'h00);
    readAll();

    finish();
  end
endmodule